// File: doc/BRIEF.md
# Indirect PHY Register Window Bridge

This bridge gives a host on a 16-bit register bus access to a bank of internal PHY management registers. The host does not load index registers. It writes a direction word once. It then performs a bus write to a composite address whose upper bits pick the PHY with a one-hot select bit and whose lower bits carry the page and the register index. The bridge decodes that address and issues a single request on an internal management port. It then waits for the acknowledge.

For a PHY write, the data of the composite bus write is passed to the selected register. For a PHY read, the data of the composite write is ignored. The fetched value lands in a data register that the host reads afterwards. A status register shows the in-flight state and a sticky flag for malformed composite addresses. The host polls that register to know when a result is ready.

Top module: `phy_window_bridge`

## Requirements
- R1: After reset the direction register, the status register (0x8001) and the data register (0x8002) read 0, and no internal request is issued.
- R2: Bit 0 of a write to 0x8000 sets the direction: 1 selects a PHY read and 0 selects a PHY write. The stored bit reads back at bit 0 of 0x8000.
- R3: A host write to an address with bit 15 set, exactly one PHY-select bit set among bits 13:9 (bit 9+n selects PHY n, for n = 0..4), bit 14 clear and bit 8 clear is accepted. It produces a one-cycle internal request that carries the binary PHY number, the page from bits 7:5 and the register index from bits 4:0. The three control addresses 0x8000 to 0x8002 are never composite.
- R4: When the direction is write, the accepted request is marked as a write and carries the host write data of the composite access to the addressed PHY register.
- R5: When the direction is read, the value returned with the acknowledge is stored in the data register (0x8002). The data register keeps its value through write accesses and rejected accesses until the next read completes.
- R6: Status bit 0 (busy) is 1 from the cycle after acceptance until the cycle after the acknowledge. A composite write seen while busy is 1, including the acknowledge cycle itself, issues no request.
- R7: A composite write with no select bit, more than one select bit, bit 14 set or bit 8 set (page above 7) issues no request and sets status bit 1 (error). This happens whether or not an access is in flight, and the error bit then stays set.
- R8: A write to 0x8001 with bit 1 set clears the error bit. A write to 0x8001 with bit 1 clear leaves the error bit unchanged.
- R9: A read strobe loads the read data output on the next clock edge with the addressed register: 0x8000 gives the direction, 0x8001 gives {error, busy} in bits 1:0, 0x8002 gives the data register, and any other address gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Host read data, registered |
| mgmt_req | output | 1 | One-cycle internal access request |
| mgmt_write | output | 1 | 1 for a PHY write, 0 for a PHY read |
| mgmt_phy | output | 3 | Binary PHY number |
| mgmt_page | output | 3 | Page number |
| mgmt_reg | output | 5 | Register index |
| mgmt_wdata | output | 16 | Data for a PHY write |
| mgmt_ack | input | 1 | Access complete, one cycle |
| mgmt_rdata | input | 16 | Read result, valid with mgmt_ack |

## Verification
Two events can fall in the same cycle: the internal acknowledge that ends an access, and a new composite host write. The bench provokes this by watching for the acknowledge pulse from its PHY model and driving a composite write in that very cycle. It judges the outcome by three things: the model's request count must not move, busy must clear on the following edge, and the data register must hold the first access's result. A second overlap is a malformed address issued while busy. It must still set the error flag, and it must leave the access in flight undisturbed.

// File: rtl/phy_window_bridge.sv
module phy_window_bridge #(
  parameter int NPHY = 5,
  parameter int DW   = 16,
  localparam int PW  = (NPHY > 1) ? $clog2(NPHY) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_wr,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  output logic          mgmt_req,
  output logic          mgmt_write,
  output logic [PW-1:0] mgmt_phy,
  output logic [2:0]    mgmt_page,
  output logic [4:0]    mgmt_reg,
  output logic [DW-1:0] mgmt_wdata,
  input  logic          mgmt_ack,
  input  logic [DW-1:0] mgmt_rdata
);
  localparam logic [15:0] A_DIR  = 16'h8000;
  localparam logic [15:0] A_STAT = 16'h8001;
  localparam logic [15:0] A_DATA = 16'h8002;

  logic          busy, err, dir_rd, cur_rd;
  logic [DW-1:0] data_q;
  logic [PW-1:0] sel_idx;

  wire        is_ctrl   = (host_addr == A_DIR) || (host_addr == A_STAT) || (host_addr == A_DATA);
  wire [5:0]  sel_field = host_addr[14:9];
  wire [NPHY-1:0] sel   = sel_field[NPHY-1:0];
  wire        comp      = host_wr && host_addr[15] && !is_ctrl;
  wire        good      = $onehot(sel) && ((sel_field >> NPHY) == 6'd0) && !host_addr[8];
  wire        start     = comp && good && !busy;
  wire        clr_err   = host_wr && (host_addr == A_STAT) && host_wdata[1];

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < NPHY; i++)
      if (sel[i]) sel_idx = PW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      err        <= 1'b0;
      dir_rd     <= 1'b0;
      cur_rd     <= 1'b0;
      data_q     <= '0;
      mgmt_req   <= 1'b0;
      mgmt_write <= 1'b0;
      mgmt_phy   <= '0;
      mgmt_page  <= '0;
      mgmt_reg   <= '0;
      mgmt_wdata <= '0;
      host_rdata <= '0;
    end else begin
      mgmt_req <= start;
      if (start) begin
        busy       <= 1'b1;
        cur_rd     <= dir_rd;
        mgmt_write <= !dir_rd;
        mgmt_phy   <= sel_idx;
        mgmt_page  <= host_addr[7:5];
        mgmt_reg   <= host_addr[4:0];
        mgmt_wdata <= host_wdata;
      end else if (busy && mgmt_ack) begin
        busy <= 1'b0;
        if (cur_rd) data_q <= mgmt_rdata;
      end

      if (comp && !good) err <= 1'b1;
      else if (clr_err)  err <= 1'b0;

      if (host_wr && host_addr == A_DIR) dir_rd <= host_wdata[0];

      if (host_rd) begin
        case (host_addr)
          A_DIR:   host_rdata <= DW'(dir_rd);
          A_STAT:  host_rdata <= DW'({err, busy});
          A_DATA:  host_rdata <= data_q;
          default: host_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/phy_window_bridge_chk.sv
module phy_window_bridge_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic [15:0]   host_addr,
  input logic [DW-1:0] host_wdata,
  input logic          mgmt_req,
  input logic          mgmt_ack,
  input logic          busy,
  input logic          err,
  input logic          cur_rd,
  input logic [DW-1:0] data_q
);
  assert_lone_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req |=> !mgmt_req);

  assert_req_decoded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req |-> ($past(host_addr[15]) && !$past(host_addr[8]) &&
                  $countones($past(host_addr[14:9])) == 1));

  assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !mgmt_req);

  assert_busy_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mgmt_ack) |=> !busy);

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && mgmt_ack && cur_rd) |=> $stable(data_q));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(host_wr && host_addr == 16'h8001 && host_wdata[1])) |=> err);
endmodule

bind phy_window_bridge phy_window_bridge_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .mgmt_req(mgmt_req), .mgmt_ack(mgmt_ack),
  .busy(busy), .err(err), .cur_rd(cur_rd), .data_q(data_q)
);

// File: tb/test_phy_window_bridge.sv
module test_phy_window_bridge;
  localparam int NPHY = 5;
  localparam int LAT  = 3;
  localparam int MEMN = NPHY * 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] host_addr = '0, host_wdata = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_rdata;
  logic        mgmt_req, mgmt_write;
  logic [2:0]  mgmt_phy, mgmt_page;
  logic [4:0]  mgmt_reg;
  logic [15:0] mgmt_wdata;
  logic        mgmt_ack = 1'b0;
  logic [15:0] mgmt_rdata = '0;

  int checks = 0, errors = 0, cycles = 0, req_count = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phy_window_bridge i_phy_window_bridge (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .mgmt_req(mgmt_req), .mgmt_write(mgmt_write), .mgmt_phy(mgmt_phy),
    .mgmt_page(mgmt_page), .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata),
    .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata));

  function automatic logic [15:0] f_init(int p, int g, int r);
    return 16'(p * 4099 + g * 131 + r * 7 + 16'h1234);
  endfunction

  function automatic logic [15:0] f_new(int p, int g, int r);
    return ~f_init(p, g, r) ^ 16'h5a5a;
  endfunction

  function automatic logic [15:0] comp_addr(int p, int g, int r);
    return 16'h8000 | 16'(1 << (9 + p)) | 16'(g << 5) | 16'(r);
  endfunction

  // PHY register model
  logic [15:0] mem [0:MEMN-1];
  int          cnt = 0;
  logic        pend_wr = 1'b0;
  int          pend_idx = 0;
  logic [15:0] pend_data = '0;
  initial for (int i = 0; i < MEMN; i++) mem[i] = f_init(i / 256, (i / 32) % 8, i % 32);

  always @(posedge clk) begin
    mgmt_ack <= 1'b0;
    if (mgmt_req) begin
      req_count <= req_count + 1;
      cnt       <= LAT;
      pend_wr   <= mgmt_write;
      pend_idx  <= int'(mgmt_phy) * 256 + int'(mgmt_page) * 32 + int'(mgmt_reg);
      pend_data <= mgmt_wdata;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mgmt_ack <= 1'b1;
        if (pend_wr) mem[pend_idx] <= pend_data;
        mgmt_rdata <= pend_wr ? 16'hdead : mem[pend_idx];
      end
    end
  end

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(logic [15:0] a, output logic [15:0] v);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    int n = 0;
    do begin
      hr(16'h8001, s);
      n++;
    end while (s[0] && n < 50);
    if (s[0]) check("R6 busy never cleared", s & 16'h1, 16'h0);
  endtask

  initial begin
    wait (cycles >= 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, last;
    int rc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 no request after reset", 16'(mgmt_req), 16'h0);
    hr(16'h8000, v); check("R1 direction reset", v, 16'h0);
    hr(16'h8001, v); check("R1 status reset", v, 16'h0);
    hr(16'h8002, v); check("R1 data reset", v, 16'h0);

    hw(16'h8000, 16'h0001); hr(16'h8000, v); check("R2 direction read", v, 16'h1);
    hw(16'h8000, 16'hfffe); hr(16'h8000, v); check("R2 direction write", v, 16'h0);
    hr(16'h1234, v); check("R9 unmapped reads zero", v, 16'h0);

    // R3 R5: full read sweep
    hw(16'h8000, 16'h0001);
    for (int p = 0; p < NPHY; p++)
      for (int g = 0; g < 8; g++)
        for (int r = 0; r < 32; r++) begin
          hw(comp_addr(p, g, r), 16'hbeef);
          wait_idle();
          hr(16'h8002, v);
          check("R3 R5 read sweep", v, f_init(p, g, r));
        end
    last = f_init(NPHY - 1, 7, 31);

    // R4: full write sweep, data register must hold
    hw(16'h8000, 16'h0000);
    for (int p = 0; p < NPHY; p++)
      for (int g = 0; g < 8; g++)
        for (int r = 0; r < 32; r++) begin
          hw(comp_addr(p, g, r), f_new(p, g, r));
          wait_idle();
        end
    hr(16'h8002, v); check("R5 data held over writes", v, last);
    hw(16'h8000, 16'h0001);
    for (int p = 0; p < NPHY; p++)
      for (int g = 0; g < 8; g++)
        for (int r = 0; r < 32; r++) begin
          hw(comp_addr(p, g, r), 16'h0);
          wait_idle();
          hr(16'h8002, v);
          check("R4 write then read back", v, f_new(p, g, r));
        end

    // R6: busy and rejection during flight
    rc = req_count;
    hw(comp_addr(2, 3, 4), 16'h0);
    hr(16'h8001, v); check("R6 busy set", v & 16'h1, 16'h1);
    hw(comp_addr(1, 1, 1), 16'h0);
    while (!mgmt_ack) @(negedge clk);
    host_addr = comp_addr(0, 0, 9); host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    hr(16'h8001, v); check("R6 busy clear after ack", v & 16'h1, 16'h0);
    repeat (8) @(negedge clk);
    check("R6 only one request", 16'(req_count - rc), 16'h1);
    hr(16'h8002, v); check("R6 R5 result of accepted access", v, f_new(2, 3, 4));

    // R7: malformed composites
    last = v;
    rc = req_count;
    hw(16'h8003, 16'h0);                           hr(16'h8001, v); check("R7 no select", v, 16'h2);
    hw(16'h8001, 16'h0001);                        hr(16'h8001, v); check("R8 clear needs bit1", v, 16'h2);
    hw(16'h8001, 16'h0002);                        hr(16'h8001, v); check("R8 clear", v, 16'h0);
    hw(16'h8600, 16'h0);                           hr(16'h8001, v); check("R7 two selects", v, 16'h2);
    hw(16'h8001, 16'h0002);
    hw(16'h8200 | 16'h0100, 16'h0);                hr(16'h8001, v); check("R7 page above 7", v, 16'h2);
    hw(16'h8001, 16'h0002);
    hw(16'hc200, 16'h0);                           hr(16'h8001, v); check("R7 bit14 set", v, 16'h2);
    repeat (8) @(negedge clk);
    check("R7 no request on malformed", 16'(req_count - rc), 16'h0);
    hr(16'h8002, v); check("R5 data held over rejects", v, last);

    // R7 while busy
    hw(16'h8001, 16'h0002);
    hw(comp_addr(4, 7, 31), 16'h0);
    hw(16'h8600, 16'h0);
    hr(16'h8001, v); check("R7 error while busy", v, 16'h3);
    wait_idle();
    hr(16'h8002, v); check("R7 flight undisturbed", v, f_new(4, 7, 31));
    hr(16'h8001, v); check("R7 error sticky", v, 16'h2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule